// File: doc/BRIEF.md
# Video Bank Address Arbiter

This block sits between a processor, a video fetch engine and one shared dual-port block RAM. The processor uses port A. The video engine uses port B. The video engine produces only a 14-bit address inside a 16 KiB window. The block adds the two upper address bits from a two-bit bank-select value. A set bank-select bit clears the matching address bit, so the select value works in inverted form.

The block also replaces the RAM data with character-ROM data for the video port in two of the four windows. It keeps the two ports from touching the same RAM word at the moments when the RAM is clocked. An internal modulo-8 phase counter times this. On the two phases used for video fetches, the processor write strobe is held low. On the phase used for processor accesses, the lowest bit of the video address is forced to the inverse of the processor address bit, so the two addresses cannot match.

Top module: `vbank_arbiter`

## Requirements
- R1: After reset the phase output is 0. It then advances by one on every clock and wraps from 7 to 0.
- R2: Port-B address bits 15:14 always equal the bitwise inverse of bank_sel[1:0]. On phases other than 7, bits 13:0 equal vid_addr.
- R3: On phase 7, port-B address bit 0 equals the inverse of cpu_addr[0]. Bits 15:1 stay as in R2.
- R4: cpu_we is 0 whenever the phase is 2 or 6, whatever the value of cpu_we_raw.
- R5: On phases 0, 1, 3, 4, 5 and 7, cpu_we equals cpu_we_raw.
- R6: vid_rdata equals crom_rdata when vid_addr[13:12] is 01 and bank_sel[0] is 1.
- R7: In every other case vid_rdata equals ram_rdata.
- R8: On phases 2, 6 and 7, a high cpu_we never coincides with cpu_addr equal to the port-B address.
- R9: The window mapping is as follows. bank_sel 11 places vid_addr at 0x0000, 10 at 0x4000, 01 at 0x8000 and 00 at 0xC000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_addr | input | 14 | Address inside the current video window |
| bank_sel | input | 2 | Inverted window select from the peripheral port |
| cpu_addr | input | 16 | Processor address on port A |
| cpu_we_raw | input | 1 | Processor write strobe before gating |
| ram_rdata | input | 8 | Read data from the RAM's video port |
| crom_rdata | input | 8 | Read data from the character ROM |
| phase | output | 3 | Current clock phase |
| pb_addr | output | 16 | Address for the RAM's video port |
| cpu_we | output | 1 | Gated processor write strobe |
| vid_rdata | output | 8 | Data returned to the video engine |

## Verification
The checker samples the inputs only at rising edges. It therefore assumes that vid_addr, bank_sel, cpu_addr and cpu_we_raw are stable around the edge, which holds because the bench changes them only on falling edges. The collision property covers only the phases at which the RAM is clocked. On the other phases the stimulus deliberately sets equal processor and video addresses with the raw strobe high, and no check is made for those phases. Each scenario waits for a chosen phase by following its own phase count, which starts from reset.

// File: rtl/vbank_pkg.sv
package vbank_pkg;
    localparam int PHASE_W = 3;
    localparam int ADDR_W  = 16;
    localparam int VADDR_W = 14;
    localparam int DATA_W  = 8;

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
    } ph_state_t;
endpackage

// File: rtl/vbank_phase.sv
module vbank_phase
    import vbank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    output logic [PHASE_W-1:0] phase
);
    ph_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.phase = st_q.phase + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase = st_q.phase;
endmodule

// File: rtl/vbank_addr.sv
module vbank_addr #(
    parameter int ADDR_W  = 16,
    parameter int VADDR_W = 14,
    parameter int PHASE_W = 3,
    parameter int SWAP_PH = 7
) (
    input  logic [VADDR_W-1:0]        vid_addr,
    input  logic [ADDR_W-VADDR_W-1:0] bank_sel,
    input  logic                      cpu_lsb,
    input  logic [PHASE_W-1:0]        phase,
    output logic [ADDR_W-1:0]         pb_addr
);
    logic [ADDR_W-1:0] ext_d;

    always_comb begin
        ext_d   = {~bank_sel, vid_addr};
        pb_addr = ext_d;
        if (phase == PHASE_W'(SWAP_PH)) pb_addr[0] = ~cpu_lsb;
    end
endmodule

// File: rtl/vbank_wgate.sv
module vbank_wgate #(
    parameter int PHASE_W = 3,
    parameter int NMASK   = 2,
    parameter int MASK_PH [NMASK] = '{2, 6}
) (
    input  logic               we_raw,
    input  logic [PHASE_W-1:0] phase,
    output logic               we
);
    logic [NMASK-1:0] hit_d;

    for (genvar g = 0; g < NMASK; g++) begin : g_mask
        assign hit_d[g] = (phase == PHASE_W'(MASK_PH[g]));
    end

    assign we = we_raw & ~(|hit_d);
endmodule

// File: rtl/vbank_rdsel.sv
module vbank_rdsel #(
    parameter int DATA_W  = 8,
    parameter int VADDR_W = 14
) (
    input  logic [1:0]        win_bits,
    input  logic              sel_lsb,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] crom_rdata,
    output logic [DATA_W-1:0] vid_rdata
);
    logic use_rom_d;

    always_comb begin
        use_rom_d = (win_bits == 2'b01) && sel_lsb;
        vid_rdata = use_rom_d ? crom_rdata : ram_rdata;
    end
endmodule

// File: rtl/vbank_arbiter.sv
module vbank_arbiter
    import vbank_pkg::*;
#(
    parameter int SWAP_PH = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [VADDR_W-1:0]        vid_addr,
    input  logic [ADDR_W-VADDR_W-1:0] bank_sel,
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic                      cpu_we_raw,
    input  logic [DATA_W-1:0]         ram_rdata,
    input  logic [DATA_W-1:0]         crom_rdata,
    output logic [PHASE_W-1:0]        phase,
    output logic [ADDR_W-1:0]         pb_addr,
    output logic                      cpu_we,
    output logic [DATA_W-1:0]         vid_rdata
);
    vbank_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    vbank_addr #(
        .ADDR_W  (ADDR_W),
        .VADDR_W (VADDR_W),
        .PHASE_W (PHASE_W),
        .SWAP_PH (SWAP_PH)
    ) u_addr (
        .vid_addr (vid_addr),
        .bank_sel (bank_sel),
        .cpu_lsb  (cpu_addr[0]),
        .phase    (phase),
        .pb_addr  (pb_addr)
    );

    vbank_wgate #(
        .PHASE_W (PHASE_W)
    ) u_wgate (
        .we_raw (cpu_we_raw),
        .phase  (phase),
        .we     (cpu_we)
    );

    vbank_rdsel #(
        .DATA_W  (DATA_W),
        .VADDR_W (VADDR_W)
    ) u_rdsel (
        .win_bits   (vid_addr[VADDR_W-1:VADDR_W-2]),
        .sel_lsb    (bank_sel[0]),
        .ram_rdata  (ram_rdata),
        .crom_rdata (crom_rdata),
        .vid_rdata  (vid_rdata)
    );
endmodule

// File: rtl/vbank_arbiter_chk.sv
module vbank_arbiter_chk
    import vbank_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic [VADDR_W-1:0]        vid_addr,
    input logic [ADDR_W-VADDR_W-1:0] bank_sel,
    input logic [ADDR_W-1:0]         cpu_addr,
    input logic                      cpu_we_raw,
    input logic [DATA_W-1:0]         ram_rdata,
    input logic [DATA_W-1:0]         crom_rdata,
    input logic [PHASE_W-1:0]        phase,
    input logic [ADDR_W-1:0]         pb_addr,
    input logic                      cpu_we,
    input logic [DATA_W-1:0]         vid_rdata
);
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> phase == $past(phase) + 3'd1); // R1
    AST_BANK_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        pb_addr[ADDR_W-1:VADDR_W] == ~bank_sel); // R2
    AST_LSB_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 3'd7 |-> pb_addr[0] != cpu_addr[0]); // R3
    AST_WE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd2 || phase == 3'd6) |-> !cpu_we); // R4
    AST_WE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != 3'd2 && phase != 3'd6) |-> cpu_we == cpu_we_raw); // R5
    AST_ROM_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_addr[13:12] == 2'b01 && bank_sel[0]) |-> vid_rdata == crom_rdata); // R6
    AST_RAM_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !(vid_addr[13:12] == 2'b01 && bank_sel[0]) |-> vid_rdata == ram_rdata); // R7
    AST_NO_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd2 || phase == 3'd6 || phase == 3'd7) |->
            !(cpu_we && cpu_addr == pb_addr)); // R8
endmodule

bind vbank_arbiter vbank_arbiter_chk i_chk (.*);

// File: tb/test_vbank_arbiter.sv
module test_vbank_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] vid_addr = '0;
    logic [1:0]  bank_sel = '0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_we_raw = 1'b0;
    logic [7:0]  ram_rdata = 8'h5A;
    logic [7:0]  crom_rdata = 8'hC3;
    logic [2:0]  phase;
    logic [15:0] pb_addr;
    logic        cpu_we;
    logic [7:0]  vid_rdata;

    int checks = 0;
    int errors = 0;
    int exp_ph = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vbank_arbiter i_vbank_arbiter (.*);

    always @(posedge clk) exp_ph <= rst_n ? (exp_ph + 1) % 8 : 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic go_phase(int p);
        while (exp_ph != p) @(negedge clk);
    endtask

    function automatic logic [15:0] exp_pb(int p);
        logic [15:0] a = {~bank_sel, vid_addr};
        if (p == 7) a[0] = ~cpu_addr[0];
        return a;
    endfunction

    task automatic t_reset;
        @(negedge clk);
        chk("R1 reset", phase, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_phase_walk;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk("R1 walk", phase, exp_ph);
        end
    endtask

    task automatic t_bank_map;
        for (int s = 0; s < 4; s++) begin
            go_phase(3);
            bank_sel = 2'(s);
            vid_addr = 14'h2A55;
            #1;
            chk("R2 bank", pb_addr, exp_pb(3));
            chk("R9 base", pb_addr & 16'hC000, 16'(3 - s) << 14);
            @(negedge clk);
        end
    endtask

    task automatic t_lsb_swap;
        for (int v = 0; v < 4; v++) begin
            go_phase(7);
            bank_sel = 2'b10;
            vid_addr = 14'(16'h1230 + v);
            cpu_addr = 16'(16'h4100 + v / 2);
            #1;
            chk("R3 swap", pb_addr, exp_pb(7));
            @(negedge clk);
        end
    endtask

    task automatic t_we_gate;
        for (int r = 0; r < 2; r++) begin
            cpu_we_raw = r[0];
            for (int p = 0; p < 8; p++) begin
                go_phase(p);
                #1;
                if (p == 2 || p == 6) chk("R4 mask", cpu_we, 0);
                else chk("R5 pass", cpu_we, r[0]);
                @(negedge clk);
            end
        end
        cpu_we_raw = 1'b0;
    endtask

    task automatic t_rom_sel;
        for (int w = 0; w < 4; w++) begin
            for (int s = 0; s < 4; s++) begin
                vid_addr = {2'(w), 12'h0F0};
                bank_sel = 2'(s);
                ram_rdata = 8'(w * 16 + s);
                crom_rdata = ~ram_rdata;
                #1;
                if (w == 1 && s[0]) chk("R6 rom", vid_rdata, crom_rdata);
                else chk("R7 ram", vid_rdata, ram_rdata);
                @(negedge clk);
            end
        end
    endtask

    task automatic t_collision;
        cpu_we_raw = 1'b1;
        bank_sel = 2'b01;
        vid_addr = 14'h0777;
        cpu_addr = {2'b10, 14'h0777};
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            #1;
            if (exp_ph == 2 || exp_ph == 6 || exp_ph == 7)
                chk("R8 collide", {31'b0, cpu_we && (cpu_addr == pb_addr)}, 0);
        end
        cpu_we_raw = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_phase_walk();
        t_bank_map();
        t_lsb_swap();
        t_we_gate();
        t_rom_sel();
        t_collision();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule